// File: doc/BRIEF.md
# Management Command Register Decoder

This block is the register file that an external management controller writes through a byte-write slave port. Each write carries an offset and one data byte. The block keeps two message bytes and a small clock-strap field, and the host reads them back through a registered read port. A write to the command offset is also decoded into a platform action, which leaves the block as a single-cycle pulse. The actions are wake, SMI, power-down, hard reset with or without a power cycle, watchdog reload, and disabling of heartbeat/event messages.

Some effects depend on state. A wake request becomes an SMI when the system already reports that it is awake. The wake and power-button-override status bits stay set until the host clears them with a write-one-to-clear strobe. The message-disable latch is not affected by the ordinary reset. It clears only when the resume-well reset input goes high and then low again.

Top module: `mgmt_cmd_regfile`

## Requirements
- R1: After the synchronous reset `rst`, every readable offset reads 0, every pulse output is 0, `rstc_o` is 0, and both status bits are 0.
- R2: Offsets 4 and 5 each hold a full message byte. A read returns the value on `rd_data` one cycle after `rd_addr` is presented. A later write always overwrites the byte. A read in the same cycle as a write to that offset returns the old value.
- R3: Offset 8 stores only `wr_data[3:0]` and reads back with bits 7:4 equal to 0, whatever was written to them.
- R4: Offset 0 stores the last command byte, which reads back unchanged. Writes to offsets 1–3, 6, 7 and 9–255 are discarded, and those offsets read 0.
- R5: Command 1 written while `sys_awake` is 0 gives a one-cycle `wake_o`. Written while `sys_awake` is 1, it gives a one-cycle `smi_o` instead. The pulse is high in the cycle after the clock edge that samples the write.
- R6: Command 2 gives a one-cycle `pwrdn_o` with the same timing as R5.
- R7: Command 3 gives a one-cycle `hrst_warm_o` with `rstc_o` = 4'b0110. Command 4 gives a one-cycle `hrst_cold_o` with `rstc_o` = 4'b1110. `rstc_o` is 0 in every other cycle.
- R8: Command 6 gives a one-cycle `wdt_reload_o` with the same timing as R5.
- R9: Commands 0 and 7–255 raise no pulse and change no status bit or latch.
- R10: `wake_sts_o` is set by command 1, whether it produced a wake or an SMI. `pwrbtn_sts_o` is set by command 2. Each sets on the clock edge after its pulse and stays set until `sts_clr[0]` (wake) or `sts_clr[1]` (power button) is 1 for a cycle. A set and a clear in the same cycle leave the bit set.
- R11: Command 5 sets `msg_dis_o` on the second clock edge after the write. `rst` does not clear it. It clears only on the clock edge that samples `rsm_rst` low after sampling it high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Slave byte write strobe |
| wr_addr | input | ADDR_W | Write offset |
| wr_data | input | DATA_W | Write data byte |
| rd_addr | input | ADDR_W | Host read offset |
| rd_data | output | DATA_W | Registered host read data |
| sys_awake | input | 1 | System is in the working state |
| rsm_rst | input | 1 | Resume-well reset, active high |
| sts_clr | input | 2 | Write-one-to-clear: bit 0 wake status, bit 1 power-button status |
| wake_o | output | 1 | Wake request pulse |
| smi_o | output | 1 | SMI request pulse |
| pwrdn_o | output | 1 | Unconditional power-down pulse |
| hrst_warm_o | output | 1 | Hard reset without power cycle pulse |
| hrst_cold_o | output | 1 | Hard reset with power cycle pulse |
| rstc_o | output | 4 | Equivalent reset-control value during a hard reset pulse |
| wdt_reload_o | output | 1 | Watchdog reload pulse |
| wake_sts_o | output | 1 | Sticky wake status |
| pwrbtn_sts_o | output | 1 | Sticky power-button-override status |
| msg_dis_o | output | 1 | Heartbeat/event message disable latch |

## Verification
The bench builds the block with its defaults: an 8-bit offset, 8-bit data, a 4-bit strap field and two message bytes. With these values the whole offset space of 256 entries can be written and read back. All 256 command codes can also be swept, once with the system asleep and once awake. The bench therefore computes the expected value of every offset and the expected side effect of every code arithmetically, with no sampling. The status clear, the case where set wins over clear, and the resume-reset sequence are driven as directed cases on top of the sweeps.

// File: rtl/mcr_pkg.sv
package mcr_pkg;
  // Offsets whose position the external controller relies on
  localparam int unsigned OFS_CMD      = 0;
  localparam int unsigned OFS_MSG_BASE = 4;
  localparam int unsigned OFS_STRAP    = 8;

  // Command codes
  localparam logic [7:0] CMD_WAKE      = 8'd1;
  localparam logic [7:0] CMD_PWRDN     = 8'd2;
  localparam logic [7:0] CMD_HRST_WARM = 8'd3;
  localparam logic [7:0] CMD_HRST_COLD = 8'd4;
  localparam logic [7:0] CMD_MSG_OFF   = 8'd5;
  localparam logic [7:0] CMD_WDT       = 8'd6;

  // Reset-control equivalents driven with the hard reset pulses
  localparam logic [3:0] RSTC_WARM = 4'b0110;
  localparam logic [3:0] RSTC_COLD = 4'b1110;

  typedef struct packed {
    logic wdt;
    logic cold;
    logic warm;
    logic pwrdn;
    logic smi;
    logic wake;
  } pulse_t;
endpackage

// File: rtl/mcr_regbank.sv
module mcr_regbank
  import mcr_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 8,
  parameter int STRAP_W = 4,
  parameter int NUM_MSG = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);
  localparam logic [ADDR_W-1:0] A_CMD   = ADDR_W'(OFS_CMD);
  localparam logic [ADDR_W-1:0] A_STRAP = ADDR_W'(OFS_STRAP);

  logic [DATA_W-1:0]  cmd_q;
  logic [STRAP_W-1:0] strap_q;
  logic [DATA_W-1:0]  msg_q [NUM_MSG];
  logic [DATA_W-1:0]  rd_next;

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_q   <= '0;
      strap_q <= '0;
    end else if (wr_en) begin
      if (wr_addr == A_CMD)   cmd_q   <= wr_data;
      if (wr_addr == A_STRAP) strap_q <= wr_data[STRAP_W-1:0];
    end
  end

  for (genvar i = 0; i < NUM_MSG; i++) begin : g_msg
    localparam logic [ADDR_W-1:0] A_MSG = ADDR_W'(OFS_MSG_BASE + i);
    always_ff @(posedge clk) begin
      if (rst)                              msg_q[i] <= '0;
      else if (wr_en && (wr_addr == A_MSG)) msg_q[i] <= wr_data;
    end
  end

  always_comb begin
    rd_next = '0;
    if (rd_addr == A_CMD)   rd_next = cmd_q;
    if (rd_addr == A_STRAP) rd_next = DATA_W'(strap_q);
    for (int i = 0; i < NUM_MSG; i++)
      if (rd_addr == ADDR_W'(OFS_MSG_BASE + i)) rd_next = msg_q[i];
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= rd_next;
  end
endmodule

// File: rtl/mcr_cmd_decode.sv
module mcr_cmd_decode
  import mcr_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_wr,
  input  logic [DATA_W-1:0] cmd_val,
  input  logic              sys_awake,
  output pulse_t            pulses_q,
  output logic [3:0]        rstc_q,
  output logic              msg_off_q
);
  pulse_t     nxt;
  logic [3:0] rstc_n;
  logic       msg_n;
  logic [7:0] code;

  assign code = cmd_val[7:0];

  always_comb begin
    nxt    = '0;
    rstc_n = '0;
    msg_n  = 1'b0;
    if (cmd_wr && (DATA_W <= 8 || cmd_val[DATA_W-1:0] == DATA_W'(code))) begin
      unique case (code)
        CMD_WAKE: begin
          if (sys_awake) nxt.smi  = 1'b1;
          else           nxt.wake = 1'b1;
        end
        CMD_PWRDN:     nxt.pwrdn = 1'b1;
        CMD_HRST_WARM: begin nxt.warm = 1'b1; rstc_n = RSTC_WARM; end
        CMD_HRST_COLD: begin nxt.cold = 1'b1; rstc_n = RSTC_COLD; end
        CMD_MSG_OFF:   msg_n = 1'b1;
        CMD_WDT:       nxt.wdt = 1'b1;
        default:       ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pulses_q  <= '0;
      rstc_q    <= '0;
      msg_off_q <= 1'b0;
    end else begin
      pulses_q  <= nxt;
      rstc_q    <= rstc_n;
      msg_off_q <= msg_n;
    end
  end
endmodule

// File: rtl/mcr_status.sv
module mcr_status (
  input  logic       clk,
  input  logic       rst,
  input  logic       rsm_rst,
  input  logic       set_wake,
  input  logic       set_pwr,
  input  logic       set_msg,
  input  logic [1:0] sts_clr,
  output logic       wake_sts,
  output logic       pwr_sts,
  output logic       msg_dis
);
  logic rsm_q;
  logic rsm_release;

  always_ff @(posedge clk) begin
    if (rst) begin
      wake_sts <= 1'b0;
      pwr_sts  <= 1'b0;
    end else begin
      wake_sts <= set_wake | (wake_sts & ~sts_clr[0]);
      pwr_sts  <= set_pwr  | (pwr_sts  & ~sts_clr[1]);
    end
  end

  // Resume-well domain: untouched by rst, cleared on release of rsm_rst
  always_ff @(posedge clk) rsm_q <= rsm_rst;
  assign rsm_release = rsm_q & ~rsm_rst;

  always_ff @(posedge clk) begin
    if (rsm_release) msg_dis <= 1'b0;
    else if (set_msg) msg_dis <= 1'b1;
  end
endmodule

// File: rtl/mgmt_cmd_regfile.sv
module mgmt_cmd_regfile
  import mcr_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 8,
  parameter int STRAP_W = 4,
  parameter int NUM_MSG = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic              sys_awake,
  input  logic              rsm_rst,
  input  logic [1:0]        sts_clr,
  output logic              wake_o,
  output logic              smi_o,
  output logic              pwrdn_o,
  output logic              hrst_warm_o,
  output logic              hrst_cold_o,
  output logic [3:0]        rstc_o,
  output logic              wdt_reload_o,
  output logic              wake_sts_o,
  output logic              pwrbtn_sts_o,
  output logic              msg_dis_o
);
  pulse_t pulses;
  logic   msg_off;
  logic   cmd_wr;

  assign cmd_wr = wr_en && (wr_addr == ADDR_W'(OFS_CMD));

  mcr_regbank #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .STRAP_W(STRAP_W), .NUM_MSG(NUM_MSG)
  ) u_bank (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  mcr_cmd_decode #(.DATA_W(DATA_W)) u_dec (
    .clk(clk), .rst(rst), .cmd_wr(cmd_wr), .cmd_val(wr_data),
    .sys_awake(sys_awake), .pulses_q(pulses), .rstc_q(rstc_o),
    .msg_off_q(msg_off)
  );

  mcr_status u_sts (
    .clk(clk), .rst(rst), .rsm_rst(rsm_rst),
    .set_wake(pulses.wake | pulses.smi), .set_pwr(pulses.pwrdn),
    .set_msg(msg_off), .sts_clr(sts_clr),
    .wake_sts(wake_sts_o), .pwr_sts(pwrbtn_sts_o), .msg_dis(msg_dis_o)
  );

  assign wake_o       = pulses.wake;
  assign smi_o        = pulses.smi;
  assign pwrdn_o      = pulses.pwrdn;
  assign hrst_warm_o  = pulses.warm;
  assign hrst_cold_o  = pulses.cold;
  assign wdt_reload_o = pulses.wdt;
endmodule

// File: rtl/mcr_checker.sv
module mcr_checker #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [DATA_W-1:0] wr_data,
  input logic [ADDR_W-1:0] rd_addr,
  input logic [DATA_W-1:0] rd_data,
  input logic              sys_awake,
  input logic              rsm_rst,
  input logic [1:0]        sts_clr,
  input logic              wake_o,
  input logic              smi_o,
  input logic              pwrdn_o,
  input logic              hrst_warm_o,
  input logic              hrst_cold_o,
  input logic [3:0]        rstc_o,
  input logic              wdt_reload_o,
  input logic              wake_sts_o,
  input logic              msg_dis_o
);
  logic cmd_wr;
  logic [5:0] pv;
  assign cmd_wr = wr_en && (wr_addr == '0);
  assign pv = {wdt_reload_o, hrst_cold_o, hrst_warm_o, pwrdn_o, smi_o, wake_o};

  AST_ONE_ACTION: assert property (@(posedge clk) disable iff (rst)
    $onehot0(pv)); // R9
  AST_WAKE_ASLEEP: assert property (@(posedge clk) disable iff (rst)
    wake_o |-> $past(cmd_wr && wr_data == DATA_W'(1) && !sys_awake)); // R5
  AST_SMI_AWAKE: assert property (@(posedge clk) disable iff (rst)
    smi_o |-> $past(cmd_wr && wr_data == DATA_W'(1) && sys_awake)); // R5
  AST_WDT_SRC: assert property (@(posedge clk) disable iff (rst)
    wdt_reload_o |-> $past(cmd_wr && wr_data == DATA_W'(6))); // R8
  AST_COLD_CODE: assert property (@(posedge clk) disable iff (rst)
    hrst_cold_o |-> rstc_o == 4'b1110); // R7
  AST_WARM_CODE: assert property (@(posedge clk) disable iff (rst)
    hrst_warm_o |-> rstc_o == 4'b0110); // R7
  AST_RESERVED_QUIET: assert property (@(posedge clk) disable iff (rst)
    $past(cmd_wr && (wr_data == '0 || wr_data > DATA_W'(6))) |-> pv == '0); // R9
  AST_STRAP_HIGH_ZERO: assert property (@(posedge clk) disable iff (rst)
    $past(rd_addr == ADDR_W'(8)) |-> rd_data[DATA_W-1:4] == '0); // R3
  AST_WAKE_STICKY: assert property (@(posedge clk) disable iff (rst)
    $fell(wake_sts_o) |-> ($past(sts_clr[0]) || $past(rst))); // R10
  AST_MSG_RELEASE: assert property (@(posedge clk)
    $fell(msg_dis_o) |-> (!$past(rsm_rst) && $past(rsm_rst, 2))); // R11
endmodule

bind mgmt_cmd_regfile mcr_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .rd_addr(rd_addr), .rd_data(rd_data), .sys_awake(sys_awake),
  .rsm_rst(rsm_rst), .sts_clr(sts_clr), .wake_o(wake_o), .smi_o(smi_o),
  .pwrdn_o(pwrdn_o), .hrst_warm_o(hrst_warm_o), .hrst_cold_o(hrst_cold_o),
  .rstc_o(rstc_o), .wdt_reload_o(wdt_reload_o), .wake_sts_o(wake_sts_o),
  .msg_dis_o(msg_dis_o)
);

// File: tb/mgmt_cmd_regfile_test.sv
module mgmt_cmd_regfile_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1, wr_en = 1'b0, sys_awake = 1'b0, rsm_rst = 1'b1;
  logic [7:0] wr_addr = '0, wr_data = '0, rd_addr = '0, rd_data;
  logic [1:0] sts_clr = '0;
  logic       wake_o, smi_o, pwrdn_o, hrst_warm_o, hrst_cold_o, wdt_reload_o;
  logic       wake_sts_o, pwrbtn_sts_o, msg_dis_o;
  logic [3:0] rstc_o;
  int n_chk = 0, n_fail = 0;

  always #4 clk = ~clk;

  mgmt_cmd_regfile uut (.*);

  function automatic logic [5:0] pv();
    return {wdt_reload_o, hrst_cold_o, hrst_warm_o, pwrdn_o, smi_o, wake_o};
  endfunction

  function automatic logic [7:0] pat(int a);
    return 8'((a * 37 + 11) & 255);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [7:0] d);
    @(negedge clk); rd_addr = a;
    @(negedge clk); d = rd_data;
  endtask

  initial begin
    #(8 * 150000);
    n_fail++;
    $display("FAIL watchdog: actual running expected done");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] v;
    logic [7:0] e;
    logic ew, ep, em;
    repeat (3) @(negedge clk);
    rsm_rst = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    chk("R1 pulses", 32'(pv()), 0);
    chk("R1 rstc", 32'(rstc_o), 0);
    chk("R1 status", 32'({wake_sts_o, pwrbtn_sts_o, msg_dis_o}), 0);
    foreach (e[i]) ;
    for (int a = 0; a < 10; a++) begin
      rd(8'(a), v); chk("R1 read", 32'(v), 0);
    end

    // Offset sweep: R2 R3 R4
    for (int a = 0; a < 256; a++) wr(8'(a), pat(a));
    for (int a = 0; a < 256; a++) begin
      rd(8'(a), v);
      if (a == 4 || a == 5)  chk("R2 msg byte", 32'(v), 32'(pat(a)));
      else if (a == 8)       chk("R3 strap", 32'(v), 32'(pat(a) & 8'h0F));
      else if (a == 0)       chk("R4 cmd readback", 32'(v), 32'(pat(a)));
      else                   chk("R4 reserved offset", 32'(v), 0);
    end

    // R2 overwrite and same-cycle collision
    wr(8'd4, 8'hAA); wr(8'd4, 8'h55);
    rd(8'd4, v); chk("R2 overwrite", 32'(v), 32'h55);
    @(negedge clk); wr_en = 1'b1; wr_addr = 8'd5; wr_data = 8'h3C; rd_addr = 8'd5;
    @(negedge clk); wr_en = 1'b0; v = rd_data;
    chk("R2 collision old value", 32'(v), 32'(pat(5)));
    rd(8'd5, v); chk("R2 new value", 32'(v), 32'h3C);

    // Command sweep: R5..R11
    ew = 1'b0; ep = 1'b0; em = 1'b0;
    for (int aw = 0; aw < 2; aw++) begin
      for (int c = 0; c < 256; c++) begin
        logic [5:0] ep_v;
        logic [3:0] er;
        string rq;
        sys_awake = aw[0];
        ep_v = '0; er = '0;
        case (c)
          1: begin ep_v = aw[0] ? 6'b000010 : 6'b000001; rq = "R5"; end
          2: begin ep_v = 6'b000100; rq = "R6"; end
          3: begin ep_v = 6'b001000; er = 4'b0110; rq = "R7"; end
          4: begin ep_v = 6'b010000; er = 4'b1110; rq = "R7"; end
          5: rq = "R11";
          6: begin ep_v = 6'b100000; rq = "R8"; end
          default: rq = "R9";
        endcase
        wr(8'd0, 8'(c));
        chk({rq, " pulse"}, 32'(pv()), 32'(ep_v));
        chk({rq, " rstc"}, 32'(rstc_o), 32'(er));
        @(negedge clk);
        chk({rq, " pulse single"}, 32'({pv(), rstc_o}), 0);
        if (c == 1) ew = 1'b1;
        if (c == 2) ep = 1'b1;
        if (c == 5) em = 1'b1;
        chk("R10 status", 32'({wake_sts_o, pwrbtn_sts_o}), 32'({ew, ep}));
        chk("R11 msg_dis", 32'(msg_dis_o), 32'(em));
      end
    end

    // R10 write-one-to-clear
    @(negedge clk); sts_clr = 2'b01;
    @(negedge clk); sts_clr = 2'b00;
    chk("R10 clear wake", 32'({wake_sts_o, pwrbtn_sts_o}), 32'b01);
    @(negedge clk); sts_clr = 2'b10;
    @(negedge clk); sts_clr = 2'b00;
    chk("R10 clear pwr", 32'({wake_sts_o, pwrbtn_sts_o}), 32'b00);
    sys_awake = 1'b0;
    wr(8'd0, 8'd1);
    sts_clr = 2'b01;
    @(negedge clk); sts_clr = 2'b00;
    chk("R10 set wins", 32'(wake_sts_o), 1);
    @(negedge clk); sts_clr = 2'b01;
    @(negedge clk); sts_clr = 2'b00;
    chk("R10 clear after", 32'(wake_sts_o), 0);

    // R11 latch survives rst, clears on resume release
    wr(8'd0, 8'd2);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); @(negedge clk); rst = 1'b0;
    chk("R11 survives rst", 32'(msg_dis_o), 1);
    chk("R1 status after rst", 32'({wake_sts_o, pwrbtn_sts_o}), 0);
    rd(8'd5, v); chk("R1 msg after rst", 32'(v), 0);
    rsm_rst = 1'b1;
    @(negedge clk); @(negedge clk);
    chk("R11 held during rsm", 32'(msg_dis_o), 1);
    rsm_rst = 1'b0;
    @(negedge clk);
    chk("R11 cleared on release", 32'(msg_dis_o), 0);
    wr(8'd0, 8'd7);
    @(negedge clk);
    chk("R9 reserved no latch", 32'(msg_dis_o), 0);

    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule